// File: doc/BRIEF.md
# Interleaved I/Q Pair Receiver

This block sits at the front of a transmit path. A single word-wide bus carries I and Q samples in alternation, one word per rising clock edge. A tag line travels with the bus and tells which channel each word belongs to. The block samples the bus and the tag on every rising edge. It joins a first-channel word with the other-channel word on the following edge to form one quadrature sample. It then presents that sample on separate I and Q outputs together with a one-cycle strobe.

Three mode inputs set the framing:
- which channel opens a pair;
- whether a high tag or a low tag marks an I word;
- whether incoming words are offset (unsigned) binary or already two's complement.

The outputs are always two's complement. The block takes the modes only while reset is held, so a mode change can never split a pair between two framings.

Top module: `iq_pair_rx`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears the pending half-pair, drives `out_valid` low, and sets `out_i` and `out_q` to zero.
- R2: A word and its tag are sampled on every rising edge outside reset. With `cfg_tag_hi_is_i` = 1 a tag of 1 marks an I word; with `cfg_tag_hi_is_i` = 0 a tag of 0 marks an I word.
- R3: With `cfg_i_first` = 1 the I word opens a pair; with `cfg_i_first` = 0 the Q word opens a pair.
- R4: When a first-channel word is followed on the next edge by an other-channel word, `out_valid` is high for exactly one cycle. That cycle begins at the rising edge after the edge that sampled the second word, and it carries both words on their own channel outputs.
- R5: A first-channel word sampled while a half-pair is pending replaces the pending word and produces no strobe.
- R6: An other-channel word sampled with no half-pair pending is discarded and produces no strobe.
- R7: With `cfg_offset_bin` = 1 the most significant bit (bit 11) of each word is inverted on its way to the output; with `cfg_offset_bin` = 0 words pass through unchanged.
- R8: While `out_valid` is low, `out_i` and `out_q` keep the last emitted pair.
- R9: The three mode inputs are taken only on edges where `rst` is high; changing them outside reset has no effect on framing or format.
- R10: If `rst` is high on the edge that would emit a completed pair, no strobe occurs and the outputs are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data-rate clock; one bus word per rising edge |
| rst | input | 1 | Synchronous reset; also loads the mode inputs |
| cfg_i_first | input | 1 | 1: I word opens a pair, 0: Q word opens a pair |
| cfg_tag_hi_is_i | input | 1 | 1: tag high marks I, 0: tag low marks I |
| cfg_offset_bin | input | 1 | 1: input is offset binary, 0: input is two's complement |
| bus_word | input | WORD_W | Interleaved sample word |
| bus_tag | input | 1 | Channel tag of the current word |
| out_i | output | WORD_W | I sample of the last pair, two's complement |
| out_q | output | WORD_W | Q sample of the last pair, two's complement |
| out_valid | output | 1 | One-cycle strobe marking a new pair |

## Verification
Pair completion and synchronous reset can land on the same edge. The bench provokes this by feeding a complete pair and then raising reset exactly on the edge that would emit it. It expects no strobe and zeroed outputs, because reset must win. A related overlap is a replacing first-channel word arriving while a half-pair is pending. The random tag streams in every mode hit this often, and the arithmetic model in the bench judges each case: only the newest pending word may appear in the next pair.

// File: rtl/iq_pair_rx.sv
module iq_pair_rx #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_i_first,
  input  logic              cfg_tag_hi_is_i,
  input  logic              cfg_offset_bin,
  input  logic [WORD_W-1:0] bus_word,
  input  logic              bus_tag,
  output logic [WORD_W-1:0] out_i,
  output logic [WORD_W-1:0] out_q,
  output logic              out_valid
);

  localparam logic [WORD_W-1:0] SIGN_FLIP = {1'b1, {(WORD_W-1){1'b0}}};

  logic              mode_i_first, mode_hi_i, mode_bin;
  logic [WORD_W-1:0] cap_word;
  logic              cap_tag, cap_v;
  logic [WORD_W-1:0] pend_word;
  logic              pend_v;

  logic              cap_is_i, cap_first, pair_done;
  logic [WORD_W-1:0] cap_tc;

  assign cap_is_i  = (cap_tag == mode_hi_i);
  assign cap_first = (cap_is_i == mode_i_first);
  assign cap_tc    = mode_bin ? (cap_word ^ SIGN_FLIP) : cap_word;
  assign pair_done = cap_v && !cap_first && pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_i_first <= cfg_i_first;
      mode_hi_i    <= cfg_tag_hi_is_i;
      mode_bin     <= cfg_offset_bin;
      cap_word     <= '0;
      cap_tag      <= 1'b0;
      cap_v        <= 1'b0;
      pend_word    <= '0;
      pend_v       <= 1'b0;
      out_i        <= '0;
      out_q        <= '0;
      out_valid    <= 1'b0;
    end else begin
      cap_word  <= bus_word;
      cap_tag   <= bus_tag;
      cap_v     <= 1'b1;
      out_valid <= pair_done;
      if (cap_v && cap_first) begin
        pend_word <= cap_tc;
        pend_v    <= 1'b1;
      end else if (cap_v) begin
        pend_v    <= 1'b0;
      end
      if (pair_done) begin
        if (mode_i_first) begin
          out_i <= pend_word;
          out_q <= cap_tc;
        end else begin
          out_q <= pend_word;
          out_i <= cap_tc;
        end
      end
    end
  end

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r8_hold_outputs: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> ($stable(out_i) && $stable(out_q)));

  a_r9_modes_frozen: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(mode_i_first) && $stable(mode_hi_i) && $stable(mode_bin)));

  a_r5_first_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (cap_v && cap_first) |=> (pend_v && !out_valid));

  a_r6_orphan_dropped: assert property (@(posedge clk) disable iff (rst)
    (cap_v && !cap_first && !pend_v) |=> (!out_valid && !pend_v));

endmodule

// File: tb/iq_pair_rx_test.sv
module iq_pair_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam logic [W-1:0] MSB = 12'h800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_i_first = 1'b1, cfg_tag_hi_is_i = 1'b1, cfg_offset_bin = 1'b0;
  logic [W-1:0] bus_word = '0;
  logic bus_tag = 1'b0;
  logic [W-1:0] out_i, out_q;
  logic out_valid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model state
  bit m_ifirst, m_hi, m_bin;
  bit m_pv;
  logic [W-1:0] m_pw;
  logic [W-1:0] m_last_i, m_last_q;
  bit exv [0:1];
  logic [W-1:0] exi [0:1];
  logic [W-1:0] exq [0:1];

  iq_pair_rx #(.WORD_W(W)) uut (
    .clk(clk), .rst(rst),
    .cfg_i_first(cfg_i_first), .cfg_tag_hi_is_i(cfg_tag_hi_is_i),
    .cfg_offset_bin(cfg_offset_bin),
    .bus_word(bus_word), .bus_tag(bus_tag),
    .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] ai, input logic [W-1:0] aq,
                       input logic av, input logic [W-1:0] ei, input logic [W-1:0] eq,
                       input logic ev);
    total++;
    if (ai !== ei || aq !== eq || av !== ev) begin
      bad++;
      $display("FAIL %s: actual i=%h q=%h v=%b expected i=%h q=%h v=%b",
               req, ai, aq, av, ei, eq, ev);
    end
  endtask

  task automatic do_reset(input bit ifirst, input bit hi, input bit bin);
    rst = 1'b1;
    cfg_i_first = ifirst; cfg_tag_hi_is_i = hi; cfg_offset_bin = bin;
    @(negedge clk);
    @(negedge clk);
    m_ifirst = ifirst; m_hi = hi; m_bin = bin;
    m_pv = 0; m_pw = '0; m_last_i = '0; m_last_q = '0;
    for (int k = 0; k < 2; k++) begin exv[k] = 0; exi[k] = '0; exq[k] = '0; end
    // R1: reset state
    check("R1", out_i, out_q, out_valid, '0, '0, 1'b0);
    rst = 1'b0;
  endtask

  // called at a negedge; checks the word driven two calls ago, drives a new one
  task automatic step(input string req, input logic [W-1:0] w, input bit is_i);
    bit first;
    logic [W-1:0] tc;
    bit nv;
    check(req, out_i, out_q, out_valid, exi[1], exq[1], exv[1]);
    tc = m_bin ? (w ^ MSB) : w;
    first = (is_i == m_ifirst);
    nv = 0;
    if (first) begin
      m_pw = tc; m_pv = 1;
    end else if (m_pv) begin
      nv = 1; m_pv = 0;
      if (m_ifirst) begin m_last_i = m_pw; m_last_q = tc; end
      else begin m_last_q = m_pw; m_last_i = tc; end
    end
    exv[1] = exv[0]; exi[1] = exi[0]; exq[1] = exq[0];
    exv[0] = nv; exi[0] = m_last_i; exq[0] = m_last_q;
    bus_word = w;
    bus_tag = (is_i == m_hi); // R2 tag encoding
    @(negedge clk);
  endtask

  task automatic flush(input string req);
    // drive orphan-free idle: repeated first-channel words never emit
    step(req, '0, m_ifirst);
    step(req, '0, m_ifirst);
  endtask

  initial begin
    @(negedge clk);
    // R7 R3 R2 R4: near-exhaustive format sweep over every mode
    for (int c = 0; c < 8; c++) begin
      do_reset(c[0], c[1], c[2]);
      for (int v = 0; v < 4096; v++) begin
        step("R7", v[W-1:0], c[0]);
        step("R4", W'(4095 - v), !c[0]);
      end
      flush("R4");
    end
    // R5 R6 R8: random tag streams with repeats and orphans in every mode
    for (int c = 0; c < 8; c++) begin
      do_reset(c[0], c[1], c[2]);
      for (int n = 0; n < 600; n++) begin
        step("R5", W'($urandom), 1'($urandom));
      end
      flush("R6");
    end
    // R6: leading orphan second-channel word, then a true pair
    do_reset(1, 0, 0);
    step("R6", 12'h123, 0);
    step("R6", 12'h456, 0);
    step("R6", 12'h7aa, 1);
    step("R6", 12'h055, 0);
    flush("R8");
    // R9: mode inputs changed outside reset are ignored
    do_reset(0, 1, 1);
    cfg_i_first = 1; cfg_tag_hi_is_i = 0; cfg_offset_bin = 0;
    for (int n = 0; n < 40; n++) begin
      step("R9", W'($urandom), n[0]);
    end
    flush("R9");
    // R10: reset on the edge that would emit a pair
    do_reset(1, 1, 0);
    step("R10", 12'h3c3, 1);
    step("R10", 12'h5a5, 0);
    rst = 1'b1;
    @(negedge clk);
    check("R10", out_i, out_q, out_valid, '0, '0, 1'b0);
    @(negedge clk);
    check("R10", out_i, out_q, out_valid, '0, '0, 1'b0);
    do_reset(1, 1, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule